// File: doc/BRIEF.md
# Serialization and Fence Drain Controller

This controller sits between instruction decode and the fetch and memory-issue stages of a small pipelined core. Each cycle it looks at one decoded operation class. A serializing operation stops instruction fetch. It pulses a flush so that younger work fetched speculatively is thrown away. It also blocks all younger memory issue until two things are true in the same cycle: the count of older in-flight operations has reached zero, and the internal store buffer has emptied to the memory port. Fetch resumes one cycle after that. A control-register write also serializes, except a write to control register 8, which is handled as an ordinary operation.

Fences work only on the data path. A load fence holds back younger loads until older loads have finished. A store fence holds back younger stores until the store buffer is empty. A full fence does both. Fetch keeps running under any fence. The store buffer is a small first-in first-out queue of posted writes. It drains one entry per cycle whenever the memory port is ready.

A serializing operation that arrives while another is still draining is kept aside. It starts its own drain after the first one completes, so the two stay in order. Serializing never asks for cache write-back, and the block has no port for it.

Top module: `ser_fence_ctrl`

## Requirements
- R1: While `rst` is high and after it, `fetch_stall`, `spec_flush`, `ld_block`, `st_block`, `sb_drain_req` and `mem_wr_valid` read 0, and the store buffer is empty.
- R2: A serializing operation (`op_class`=1) accepted at a clock edge raises `fetch_stall` after that edge. `spec_flush` is high for exactly that one cycle.
- R3: `fetch_stall` stays high while `older_cnt` is nonzero or the store buffer holds entries. It falls two edges after the first edge at which both are zero.
- R4: While `fetch_stall` is high, `ld_block` and `st_block` are high, and a store offered on `st_valid` is not taken into the buffer.
- R5: A control-register write (`op_class`=5) to `op_creg` other than 8 serializes exactly like class 1. With `op_creg`=8 it is an ordinary operation and leaves every output unchanged.
- R6: A load fence (`op_class`=2) sets `ld_block` after its edge. `ld_block` stays set until the edge after `ld_pending` is seen at 0. `fetch_stall` and `st_block` are unaffected.
- R7: A store fence (`op_class`=3) sets `st_block` until the buffer is seen empty. `sb_drain_req` is high while the fence is active and the buffer is not empty.
- R8: A full fence (`op_class`=4) applies both the load and the store conditions, each released on its own.
- R9: Stores leave in arrival order, at most one per cycle, on each edge where `mem_wr_valid` and `mem_wr_ready` are both high. While the port is not ready, the head's address and data hold steady.
- R10: With DEPTH (4) entries buffered, `st_block` is high and a further store is dropped.
- R11: A second serializing operation that arrives during a drain gets its own flush pulse and drain after the first. `fetch_stall` does not fall between the two.
- R12: Class 0 (normal) and classes 6 and 7 have no effect on the controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A decoded operation is present |
| op_class | input | 3 | Operation class (0 normal, 1 serialize, 2 load fence, 3 store fence, 4 full fence, 5 control-register write) |
| op_creg | input | 4 | Target control register for class 5 |
| older_cnt | input | CNTW | Older operations still in flight |
| ld_pending | input | LDW | Older loads still outstanding |
| st_valid | input | 1 | Store offered to the buffer |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| mem_wr_ready | input | 1 | Memory port accepts a write |
| mem_wr_valid | output | 1 | Buffer head is presented |
| mem_wr_addr | output | AW | Head address |
| mem_wr_data | output | DW | Head data |
| fetch_stall | output | 1 | Halt instruction fetch |
| spec_flush | output | 1 | One-cycle discard of speculative work |
| ld_block | output | 1 | Hold younger loads |
| st_block | output | 1 | Hold younger stores |
| sb_drain_req | output | 1 | Buffer must drain for ordering |

## Verification
Every control output comes from a register. An operation or store driven before edge k therefore shows at the outputs after edge k. The bench drives and samples on falling edges, so it reads each result at the first falling edge after k. Release is slower. The drain condition is registered into a resume state, and `fetch_stall` drops only after a second edge. The bench checks that it is still high one falling edge after the condition is met and low at the next one. A store fence clears one edge after the buffer is seen empty, which makes `st_block` lag the final pop by one cycle, and the bench expects that extra cycle.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [2:0] {
    OP_NORM = 3'd0,
    OP_SER  = 3'd1,
    OP_LFEN = 3'd2,
    OP_SFEN = 3'd3,
    OP_MFEN = 3'd4,
    OP_CRW  = 3'd5
  } op_cls_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_DRAIN  = 2'd1,
    S_RESUME = 2'd2
  } seq_st_e;

  // control register whose write does not serialize
  localparam logic [3:0] CREG_NOSER = 4'd8;
endpackage

// File: rtl/sfc_store_fifo.sv
module sfc_store_fifo #(
  parameter int unsigned W     = 48,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTRW:0] CNT_FULL = (PTRW+1)'(DEPTH);

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wr_ptr, rd_ptr;
  logic [PTRW:0]   cnt;
  logic            do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_FULL);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTRW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTRW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sfc_seq_fsm.sv
module sfc_seq_fsm
  import sfc_pkg::*;
#(
  parameter int unsigned CNTW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_req,
  input  logic [CNTW-1:0] older_cnt,
  input  logic            sb_empty,
  output logic            fetch_stall,
  output logic            spec_flush
);
  seq_st_e st_q, st_n;
  logic    pend_q, pend_n;
  logic    quiet;

  assign quiet = (older_cnt == '0) && sb_empty;

  always_comb begin
    st_n   = st_q;
    pend_n = pend_q;
    unique case (st_q)
      S_IDLE:   if (ser_req) st_n = S_DRAIN;
      S_DRAIN: begin
        if (ser_req) pend_n = 1'b1;
        if (quiet)   st_n = S_RESUME;
      end
      S_RESUME: begin
        if (pend_q || ser_req) begin
          st_n   = S_DRAIN;
          pend_n = 1'b0;
        end else begin
          st_n = S_IDLE;
        end
      end
      default:  st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      pend_q     <= 1'b0;
      spec_flush <= 1'b0;
    end else begin
      st_q       <= st_n;
      pend_q     <= pend_n;
      spec_flush <= (st_n == S_DRAIN) && (st_q != S_DRAIN);
    end
  end

  assign fetch_stall = (st_q != S_IDLE);
endmodule

// File: rtl/sfc_fence_track.sv
module sfc_fence_track #(
  parameter int unsigned LDW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_fence,
  input  logic           st_fence,
  input  logic [LDW-1:0] ld_pending,
  input  logic           sb_empty,
  output logic           ld_hold,
  output logic           st_hold
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_hold <= 1'b0;
      st_hold <= 1'b0;
    end else begin
      if (ld_fence)                ld_hold <= 1'b1;
      else if (ld_pending == '0)   ld_hold <= 1'b0;
      if (st_fence)                st_hold <= 1'b1;
      else if (sb_empty)           st_hold <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_fence_ctrl.sv
module ser_fence_ctrl
  import sfc_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNTW  = 4,
  parameter int unsigned LDW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [2:0]      op_class,
  input  logic [3:0]      op_creg,
  input  logic [CNTW-1:0] older_cnt,
  input  logic [LDW-1:0]  ld_pending,
  input  logic            st_valid,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic            mem_wr_ready,
  output logic            mem_wr_valid,
  output logic [AW-1:0]   mem_wr_addr,
  output logic [DW-1:0]   mem_wr_data,
  output logic            fetch_stall,
  output logic            spec_flush,
  output logic            ld_block,
  output logic            st_block,
  output logic            sb_drain_req
);
  localparam int unsigned EW = AW + DW;

  op_cls_e       cls;
  logic          is_ser, is_lf, is_sf;
  logic          sb_empty, sb_full, ld_hold, st_hold;
  logic [EW-1:0] head;

  assign cls    = op_cls_e'(op_class);
  assign is_ser = op_valid && ((cls == OP_SER) ||
                               ((cls == OP_CRW) && (op_creg != CREG_NOSER)));
  assign is_lf  = op_valid && ((cls == OP_LFEN) || (cls == OP_MFEN));
  assign is_sf  = op_valid && ((cls == OP_SFEN) || (cls == OP_MFEN));

  sfc_store_fifo #(.W(EW), .DEPTH(DEPTH)) u_sb (
    .clk   (clk),
    .rst   (rst),
    .push  (st_valid && !st_block),
    .din   ({st_addr, st_data}),
    .pop   (mem_wr_ready),
    .dout  (head),
    .empty (sb_empty),
    .full  (sb_full)
  );

  sfc_seq_fsm #(.CNTW(CNTW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .ser_req     (is_ser),
    .older_cnt   (older_cnt),
    .sb_empty    (sb_empty),
    .fetch_stall (fetch_stall),
    .spec_flush  (spec_flush)
  );

  sfc_fence_track #(.LDW(LDW)) u_fen (
    .clk        (clk),
    .rst        (rst),
    .ld_fence   (is_lf),
    .st_fence   (is_sf),
    .ld_pending (ld_pending),
    .sb_empty   (sb_empty),
    .ld_hold    (ld_hold),
    .st_hold    (st_hold)
  );

  assign mem_wr_valid = !sb_empty;
  assign mem_wr_addr  = head[EW-1:DW];
  assign mem_wr_data  = head[DW-1:0];
  assign ld_block     = ld_hold || fetch_stall;
  assign st_block     = st_hold || fetch_stall || sb_full;
  assign sb_drain_req = !sb_empty && (st_hold || fetch_stall);
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int unsigned AW   = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned CNTW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [CNTW-1:0] older_cnt,
  input logic            mem_wr_ready,
  input logic            mem_wr_valid,
  input logic [AW-1:0]   mem_wr_addr,
  input logic [DW-1:0]   mem_wr_data,
  input logic            fetch_stall,
  input logic            spec_flush,
  input logic            ld_block,
  input logic            st_block,
  input logic            sb_drain_req
);
  p_flush_stalls_r2: assert property (@(posedge clk) disable iff (rst)
    spec_flush |-> fetch_stall);

  p_flush_single_r2: assert property (@(posedge clk) disable iff (rst)
    spec_flush |=> !spec_flush);

  p_release_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(fetch_stall) |-> ($past(older_cnt, 2) == '0));

  p_blocks_held_r4: assert property (@(posedge clk) disable iff (rst)
    fetch_stall |-> (ld_block && st_block));

  p_drain_has_data_r7: assert property (@(posedge clk) disable iff (rst)
    sb_drain_req |-> mem_wr_valid);

  p_head_steady_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
endmodule

bind ser_fence_ctrl sfc_checker #(.AW(AW), .DW(DW), .CNTW(CNTW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .older_cnt    (older_cnt),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .fetch_stall  (fetch_stall),
  .spec_flush   (spec_flush),
  .ld_block     (ld_block),
  .st_block     (st_block),
  .sb_drain_req (sb_drain_req)
);

// File: tb/sim_ser_fence_ctrl.sv
`timescale 1ns/1ps
module sim_ser_fence_ctrl;
  localparam int AW = 16, DW = 32, CNTW = 4, LDW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic op_valid = 0;
  logic [2:0] op_class = 0;
  logic [3:0] op_creg = 0;
  logic [CNTW-1:0] older_cnt = 0;
  logic [LDW-1:0] ld_pending = 0;
  logic st_valid = 0;
  logic [AW-1:0] st_addr = 0;
  logic [DW-1:0] st_data = 0;
  logic mem_wr_ready = 0;
  logic mem_wr_valid, fetch_stall, spec_flush, ld_block, st_block, sb_drain_req;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ser_fence_ctrl #(.AW(AW), .DW(DW), .DEPTH(4), .CNTW(CNTW), .LDW(LDW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_op(input logic [2:0] c, input logic [3:0] cr = 0);
    op_valid = 1; op_class = c; op_creg = cr;
    step();
    op_valid = 0; op_class = 0; op_creg = 0;
  endtask

  task automatic push_st(input logic [AW-1:0] a, input logic [DW-1:0] d);
    st_valid = 1; st_addr = a; st_data = d;
    step();
    st_valid = 0;
  endtask

  task automatic t_reset();
    chk({fetch_stall, spec_flush, ld_block, st_block, sb_drain_req, mem_wr_valid} == 0,
        "R1 outputs idle after reset",
        {fetch_stall, spec_flush, ld_block, st_block, sb_drain_req, mem_wr_valid}, 0);
  endtask

  task automatic t_normal();
    send_op(3'd0); send_op(3'd6); send_op(3'd7);
    chk({fetch_stall, spec_flush, ld_block, st_block} == 0, "R12 normal classes ignored",
        {fetch_stall, spec_flush, ld_block, st_block}, 0);
  endtask

  task automatic t_serialize();
    mem_wr_ready = 0;
    push_st(16'h0010, 32'hA0); push_st(16'h0020, 32'hA1);
    older_cnt = 3;
    send_op(3'd1);
    chk(fetch_stall && spec_flush, "R2 stall and flush after serialize", {fetch_stall, spec_flush}, 2'b11);
    chk(ld_block && st_block, "R4 blocks during serialize", {ld_block, st_block}, 2'b11);
    push_st(16'h0030, 32'hA2);
    chk(!spec_flush, "R2 flush is one cycle", spec_flush, 0);
    older_cnt = 0;
    step(3);
    chk(fetch_stall, "R3 stall held with buffered stores", fetch_stall, 1);
    chk(sb_drain_req, "R7 drain request while serializing", sb_drain_req, 1);
    mem_wr_ready = 1;
    chk(mem_wr_addr == 16'h0010, "R9 first store first", mem_wr_addr, 16'h0010);
    step();
    chk(mem_wr_addr == 16'h0020 && mem_wr_data == 32'hA1, "R9 second store next", mem_wr_addr, 16'h0020);
    step();
    chk(!mem_wr_valid, "R4 blocked store not buffered", mem_wr_valid, 0);
    step();
    chk(fetch_stall, "R3 stall one cycle after quiet", fetch_stall, 1);
    step();
    chk(!fetch_stall && !ld_block && !st_block, "R3 stall released", {fetch_stall, ld_block, st_block}, 0);
  endtask

  task automatic t_older_only();
    older_cnt = 2;
    send_op(3'd1);
    step(4);
    chk(fetch_stall, "R3 stall held while older work remains", fetch_stall, 1);
    older_cnt = 0;
    step();
    chk(fetch_stall, "R3 resume cycle still stalled", fetch_stall, 1);
    step();
    chk(!fetch_stall, "R3 released after older work", fetch_stall, 0);
  endtask

  task automatic t_creg();
    send_op(3'd5, 4'd8);
    chk(!fetch_stall && !spec_flush, "R5 write to register 8 does not serialize", {fetch_stall, spec_flush}, 0);
    send_op(3'd5, 4'd3);
    chk(fetch_stall && spec_flush, "R5 other control write serializes", {fetch_stall, spec_flush}, 2'b11);
    step(2);
    chk(!fetch_stall, "R5 control write drain done", fetch_stall, 0);
  endtask

  task automatic t_lfence();
    ld_pending = 2;
    send_op(3'd2);
    chk(ld_block && !fetch_stall && !st_block, "R6 load fence blocks loads only",
        {ld_block, fetch_stall, st_block}, 3'b100);
    step(2);
    chk(ld_block, "R6 held while loads pending", ld_block, 1);
    ld_pending = 0;
    step();
    chk(!ld_block, "R6 released after loads done", ld_block, 0);
  endtask

  task automatic t_sfence();
    mem_wr_ready = 0;
    push_st(16'h0100, 32'hB0);
    send_op(3'd3);
    chk(st_block && sb_drain_req && !fetch_stall && !ld_block, "R7 store fence state",
        {st_block, sb_drain_req, fetch_stall, ld_block}, 4'b1100);
    mem_wr_ready = 1;
    step();
    chk(st_block && !sb_drain_req, "R7 fence clears a cycle after empty", {st_block, sb_drain_req}, 2'b10);
    step();
    chk(!st_block, "R7 store fence released", st_block, 0);
  endtask

  task automatic t_mfence();
    ld_pending = 1;
    send_op(3'd4);
    chk(ld_block && st_block && !fetch_stall, "R8 full fence blocks both", {ld_block, st_block, fetch_stall}, 3'b110);
    step();
    chk(ld_block && !st_block, "R8 store side released on its own", {ld_block, st_block}, 2'b10);
    ld_pending = 0;
    step();
    chk(!ld_block, "R8 load side released", ld_block, 0);
  endtask

  task automatic t_full();
    mem_wr_ready = 0;
    for (int i = 0; i < 4; i++) push_st(16'(16'h0200 + i), 32'(32'hC0 + i));
    chk(st_block, "R10 block when full", st_block, 1);
    push_st(16'h02FF, 32'hDEAD);
    step(2);
    chk(mem_wr_valid && mem_wr_addr == 16'h0200, "R9 head steady while not ready", mem_wr_addr, 16'h0200);
    mem_wr_ready = 1;
    for (int i = 0; i < 4; i++) begin
      chk(mem_wr_valid && mem_wr_addr == 16'(16'h0200 + i) && mem_wr_data == 32'(32'hC0 + i),
          "R9 drain order", mem_wr_addr, 16'(16'h0200 + i));
      step();
    end
    chk(!mem_wr_valid, "R10 store offered while full dropped", mem_wr_valid, 0);
  endtask

  task automatic t_back2back();
    int flushes = 0, falls = 0;
    logic prev;
    older_cnt = 1;
    send_op(3'd1);
    if (spec_flush) flushes++;
    send_op(3'd1);
    prev = fetch_stall;
    older_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      if (spec_flush) flushes++;
      if (prev && !fetch_stall) falls++;
      prev = fetch_stall;
      step();
    end
    chk(flushes == 2, "R11 second serialize gets its own flush", flushes, 2);
    chk(falls == 1 && !fetch_stall, "R11 stall continuous across both", falls, 1);
  endtask

  initial begin
    step(3);
    t_reset();
    rst = 0;
    step();
    t_reset();
    t_normal();
    t_serialize();
    t_older_only();
    t_creg();
    t_lfence();
    t_sfence();
    t_mfence();
    t_full();
    t_back2back();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule